// File: doc/BRIEF.md
# Warp Load Coalescer

This unit sits between a warp's load pipeline and the memory system. It takes a single warp-wide load: one 4-byte word address for each of 32 lanes, and a mask that says which lanes take part. It sorts the active lanes by the 128-byte aligned segment each one touches. For every distinct segment it emits one line-sized memory transaction. A warp whose lanes read consecutive aligned words costs a single transaction. A warp whose lanes are spread out costs up to one transaction per lane.

A request is taken on a valid/ready handshake when the unit is idle. The unit latches the addresses and the mask, and then offers transactions one at a time on a valid/ready output. Each transaction carries the segment base address and a bitmap of the lanes that the segment serves. The issue order follows the lowest-numbered active lane that is still unserved. Once every active lane has been covered, the unit pulses `done` for one cycle, shows the number of transactions it issued, and goes back to idle. Returning data, caching and merging stores are handled elsewhere.

The controller has three states. `ST_IDLE` waits for a request. `ST_ISSUE` offers transactions. `ST_DONE` reports completion. The transitions are:
- IDLE→ISSUE on an accepted request with a non-empty mask.
- IDLE→DONE on an accepted request with an empty mask.
- ISSUE→ISSUE on a handshake that leaves lanes unserved, or while the consumer stalls.
- ISSUE→DONE on the handshake that serves the last lanes.
- DONE→IDLE unconditionally.

Top module: `warp_coalescer`

## Requirements
- R1: After reset the unit is idle. `req_ready` is 1, and `txn_valid` and `done` are 0.
- R2: `req_ready` is high only in the idle state. While a request is in progress, new requests are not accepted.
- R3: The segment of an address is that address with its low 7 bits cleared. `txn_base` always has its low 7 bits zero.
- R4: When all 32 lanes are active and lane i reads base+4·i from a 128-byte aligned base, exactly one transaction is issued. Its lane bitmap is all ones.
- R5: A stride of two words (lane i reads base+8·i, aligned base) gives exactly two transactions. The first has bitmap 0x0000FFFF and the second has 0xFFFF0000.
- R6: When every lane falls in its own segment, 32 transactions are issued, each with exactly one lane set, in increasing lane order.
- R7: Each transaction serves the segment of the lowest-numbered active lane that has not yet been served. Its bitmap has bit i set for every unserved active lane i in that segment.
- R8: Lanes whose mask bit is 0 never appear in a bitmap and cause no transaction.
- R9: An all-zero mask issues no transaction. `done` rises in the cycle after acceptance and reports a count of 0.
- R10: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base` and `txn_lanes` hold their values.
- R11: The bitmaps of one request are disjoint and together equal the mask. `done` is a one-cycle pulse in the cycle after the last handshake, and `txn_count` then equals the number of transactions issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp load request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | 1024 | Per-lane byte addresses, lane i at bits [32·i+31:32·i] |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | Memory side takes the offered transaction |
| txn_base | output | 32 | Segment base address of the transaction |
| txn_lanes | output | 32 | Lanes served by the transaction |
| done | output | 1 | One-cycle pulse when the request is finished |
| txn_count | output | 6 | Transactions issued for the request, valid with `done` |

## Verification
The bench covers four corner cases that a faulty design would get wrong:
- An unaligned run of consecutive words that straddles two segments. A unit that grouped lanes by word index instead of by address would report one transaction where two are needed.
- A mask with only the high lanes set. A unit that ignored the mask, or picked its leader from the wrong end, would issue transactions for dead lanes or in the wrong order.
- An empty mask. A design that always entered the issue state would stall or emit a bogus transaction instead of finishing at once with count zero.
- A consumer that stalls. A unit that advanced without a handshake would drop a segment or change the offered transaction in flight.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } coal_state_e;

endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [LANES*ADDR_W-1:0]   addr_in,
    input  logic [LANES-1:0]          mask_in,
    input  logic                      clr_en,
    input  logic [LANES-1:0]          clr_lanes,
    output logic [LANES*ADDR_W-1:0]   addr_out,
    output logic [LANES-1:0]          pending
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [ADDR_W-1:0] addr_q;
            logic              pend_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                    pend_q <= 1'b0;
                end else if (load) begin
                    addr_q <= addr_in[g*ADDR_W +: ADDR_W];
                    pend_q <= mask_in[g];
                end else if (clr_en && clr_lanes[g]) begin
                    pend_q <= 1'b0;
                end
            end

            assign addr_out[g*ADDR_W +: ADDR_W] = addr_q;
            assign pending[g]                   = pend_q;
        end
    endgenerate

endmodule

// File: rtl/coal_pick.sv
module coal_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] pending,
    output logic [IDX_W-1:0] leader,
    output logic             any
);

    always_comb begin
        leader = '0;
        any    = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                leader = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/coal_match.sv
module coal_match #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 7,
    localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES-1:0]        pending,
    input  logic [IDX_W-1:0]        leader,
    output logic [ADDR_W-1:0]       base,
    output logic [LANES-1:0]        lanes
);

    localparam int TAG_W = ADDR_W - SEG_BITS;

    logic [ADDR_W-1:0] lead_addr;
    logic [TAG_W-1:0]  lead_tag;

    assign lead_addr = addr[leader*ADDR_W +: ADDR_W];
    assign lead_tag  = lead_addr[ADDR_W-1:SEG_BITS];
    assign base      = {lead_tag, {SEG_BITS{1'b0}}};

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_cmp
            logic [TAG_W-1:0] tag;
            assign tag      = addr[g*ADDR_W+SEG_BITS +: TAG_W];
            assign lanes[g] = pending[g] && (tag == lead_tag);
        end
    endgenerate

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 7,
    localparam int CNT_W   = $clog2(LANES + 1),
    localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]        req_mask,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_base,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    done,
    output logic [CNT_W-1:0]        txn_count
);
    import coal_pkg::*;

    coal_state_e state_q, state_d;

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        pending;
    logic [IDX_W-1:0]        leader;
    logic                    any_pending;
    logic [ADDR_W-1:0]       seg_base;
    logic [LANES-1:0]        seg_lanes;
    logic                    accept;
    logic                    fire;
    logic                    last_fire;
    logic [CNT_W-1:0]        count_q;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign fire      = (state_q == ST_ISSUE) && txn_ready && any_pending;
    assign last_fire = fire && ((pending & ~seg_lanes) == '0);

    coal_lane_store #(.LANES(LANES), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .addr_in   (req_addr),
        .mask_in   (req_mask),
        .clr_en    (fire),
        .clr_lanes (seg_lanes),
        .addr_out  (addr_q),
        .pending   (pending)
    );

    coal_pick #(.LANES(LANES)) u_pick (
        .pending (pending),
        .leader  (leader),
        .any     (any_pending)
    );

    coal_match #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_match (
        .addr    (addr_q),
        .pending (pending),
        .leader  (leader),
        .base    (seg_base),
        .lanes   (seg_lanes)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transaction counter
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (accept) count_q <= '0;
        else if (fire)   count_q <= count_q + CNT_W'(1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (req_mask == '0) ? ST_DONE : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (last_fire || !any_pending) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        txn_valid = 1'b0;
        txn_base  = '0;
        txn_lanes = '0;
        done      = 1'b0;
        txn_count = count_q;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                txn_valid = any_pending;
                txn_base  = seg_base;
                txn_lanes = seg_lanes;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
    parameter int LANES    = 32,
    parameter int ADDR_W   = 32,
    parameter int SEG_BITS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_mask,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_base,
    input logic [LANES-1:0]  txn_lanes,
    input logic              done
);
    logic [LANES-1:0] mask_lat;
    logic [LANES-1:0] served;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_lat <= '0;
            served   <= '0;
        end else if (req_valid && req_ready) begin
            mask_lat <= req_mask;
            served   <= '0;
        end else if (txn_valid && txn_ready) begin
            served <= served | txn_lanes;
        end
    end

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_base[SEG_BITS-1:0] == '0));

    a_r7_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes != '0));

    a_r8_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_lanes & ~mask_lat) == '0));

    a_r9_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> done);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_lanes)));

    a_r11_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_lanes & served) == '0));

    a_r11_cover_all: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (served == mask_lat));

    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind warp_coalescer warp_coalescer_chk #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_lanes (txn_lanes),
    .done      (done)
);

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int CW    = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [LANES*AW-1:0]  req_addr = '0;
    logic [LANES-1:0]     req_mask = '0;
    logic                 txn_valid;
    logic                 txn_ready = 1'b1;
    logic [AW-1:0]        txn_base;
    logic [LANES-1:0]     txn_lanes;
    logic                 done;
    logic [CW-1:0]        txn_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    warp_coalescer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_lanes(txn_lanes),
        .done(done), .txn_count(txn_count)
    );

    // base, stride in bytes, mask, expected count, expected first bitmap
    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [31:0] mask;
        logic [31:0] cnt;
        logic [31:0] first;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h1000, 32'd4,   32'hFFFF_FFFF, 32'd1,  32'hFFFF_FFFF}, // R4
        '{32'h2000, 32'd8,   32'hFFFF_FFFF, 32'd2,  32'h0000_FFFF}, // R5
        '{32'h0000, 32'd128, 32'hFFFF_FFFF, 32'd32, 32'h0000_0001}, // R6
        '{32'h1040, 32'd4,   32'hFFFF_FFFF, 32'd2,  32'h0000_FFFF}, // R3 unaligned
        '{32'h3000, 32'd4,   32'h0000_FFFF, 32'd1,  32'h0000_FFFF}, // R8
        '{32'h0044, 32'd0,   32'hFFFF_FFFF, 32'd1,  32'hFFFF_FFFF}, // R7
        '{32'h0000, 32'd16,  32'hFFFF_FFFF, 32'd4,  32'h0000_00FF}, // R7
        '{32'h0000, 32'd128, 32'hF000_0000, 32'd4,  32'h1000_0000}  // R8
    };

    logic [AW-1:0] lane_addr [LANES];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pack_addr();
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = lane_addr[i];
    endtask

    // Issue a request and follow it to done with a reference of the spec.
    task automatic run_req(input logic [31:0] mask, input logic [31:0] exp_cnt,
                           input logic [31:0] exp_first, input string tag);
        logic [31:0] pend;
        logic [31:0] want;
        logic [31:0] seg;
        int          n;
        int          lead;
        bit          fin;
        pend = mask;
        n    = 0;
        fin  = 0;
        pack_addr();
        @(negedge clk);
        req_mask  = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
            if (done) begin
                chk(txn_count == exp_cnt[CW-1:0], tag, 64'(txn_count), 64'(exp_cnt));
                chk(pend == 0, "R11", 64'(pend), 64'd0);
                fin = 1;
            end else if (txn_valid) begin
                lead = -1;
                for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
                want = '0;
                seg  = '0;
                if (lead >= 0) begin
                    seg = lane_addr[lead] & 32'hFFFF_FF80;
                    for (int i = 0; i < LANES; i++)
                        if (pend[i] && ((lane_addr[i] & 32'hFFFF_FF80) == seg)) want[i] = 1'b1;
                end
                chk(txn_lanes == want, "R7", 64'(txn_lanes), 64'(want));
                chk(txn_base == seg, "R3", 64'(txn_base), 64'(seg));
                if (n == 0) chk(txn_lanes == exp_first, tag, 64'(txn_lanes), 64'(exp_first));
                chk(!req_ready, "R2", 64'(req_ready), 64'd0);
                pend = pend & ~want;
                n++;
                if (lead < 0) pend = '0;
            end
            if (!fin) @(negedge clk);
        end
        chk(fin, "R11", 64'(fin), 64'd1);
        chk(n == int'(exp_cnt), tag, 64'(n), 64'(exp_cnt));
        @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] held_b;
        logic [31:0]   held_l;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1);
        chk(txn_valid == 1'b0, "R1", 64'(txn_valid), 64'd0);
        chk(done == 1'b0, "R1", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[k]) begin
            for (int i = 0; i < LANES; i++) lane_addr[i] = VECS[k].base + VECS[k].stride * i;
            run_req(VECS[k].mask, VECS[k].cnt, VECS[k].first, $sformatf("R4-6 vec%0d", k));
        end

        // R6 scattered: second transaction holds only lane 1, checked via R7 model too
        // R7 interleaved segments: even lanes seg 0x0, odd lanes seg 0x400
        for (int i = 0; i < LANES; i++) lane_addr[i] = (i % 2) ? 32'h400 + 4 * i : 4 * i;
        run_req(32'hFFFF_FFFF, 32'd2, 32'h5555_5555, "R7");

        // R9 empty mask: done in the first cycle after acceptance
        pack_addr();
        @(negedge clk);
        req_mask  = '0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R9", 64'(done), 64'd1);
        chk(txn_valid == 1'b0, "R9", 64'(txn_valid), 64'd0);
        chk(txn_count == 0, "R9", 64'(txn_count), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R11", 64'(done), 64'd0);
        chk(req_ready == 1'b1, "R2", 64'(req_ready), 64'd1);

        // R10 stall: hold ready low, offer must not change
        for (int i = 0; i < LANES; i++) lane_addr[i] = 32'h5000 + 8 * i;
        pack_addr();
        txn_ready = 1'b0;
        req_mask  = '1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        held_b = txn_base;
        held_l = txn_lanes;
        chk(txn_valid == 1'b1, "R10", 64'(txn_valid), 64'd1);
        repeat (3) begin
            @(negedge clk);
            chk(txn_valid && txn_base == held_b && txn_lanes == held_l, "R10",
                64'(txn_lanes), 64'(held_l));
        end
        // R2 request while busy is not taken
        req_mask  = 32'h1;
        req_valid = 1'b1;
        chk(req_ready == 1'b0, "R2", 64'(req_ready), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        txn_ready = 1'b1;
        chk(txn_lanes == 32'h0000_FFFF && txn_base == 32'h5000, "R5", 64'(txn_lanes), 64'h0000FFFF);
        @(negedge clk);
        chk(txn_lanes == 32'hFFFF_0000 && txn_base == 32'h5080, "R5", 64'(txn_lanes), 64'hFFFF0000);
        @(negedge clk);
        chk(done == 1'b1 && txn_count == 2, "R11", 64'(txn_count), 64'd2);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule